// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit control and status word on a simple register bus. It records why the system was last reset, in sticky status bits that software clears by writing 1. It also lets software ask for a reset: setting one of two request bits raises a one-cycle system reset request. Software can ask for a soft power-on reset or for a soft externally-initiated reset.

The block keeps a "first reset pending" flag. Power-up sets the flag. A soft power-on request sets it again. While the flag is set, the next system reset loads the word with only the power-on cause bit and clears the flag. Any later system reset leaves the word unchanged, so software can still read the cause after a warm reset. Two button event inputs record button-initiated resets. The system's own reset sequencer drives `sys_rst`. Button debounce and the sequencing of the rest of the system are handled elsewhere.

The word sits in the upper half of an 8-byte slot, selected when address bit 2 is high. The lower half reads as zero and takes no writes. Reads are combinational.

Top module: `rst_ctrl_stat`

## Requirements
- R1: After power-up (`pwr_rst_n` low, then high), the word is 0, `first_rst_pend` is 1 and `rst_req` is 0.
- R2: A `sys_rst` cycle while `first_rst_pend` is 1 loads the word with 0x80000000 (bit 31 only) and clears `first_rst_pend`. A `sys_rst` cycle while the flag is 0 leaves the word unchanged.
- R3: Write data is masked with 0xF8000000 before use. Bits 26:0 always read as 0, and writing only those bits changes nothing.
- R4: Bits 31 (power-on cause), 28 (button power-on cause) and 27 (button external cause) are write-1-to-clear. Writing 0 to them leaves them unchanged.
- R5: Bits 30 (soft power-on request) and 29 (soft external request) are set by writing 1. Writing 0 does not clear them.
- R6: An upper-word write with bit 30 set gives `rst_req` high for exactly the next cycle and sets `first_rst_pend`.
- R7: An upper-word write with bit 29 set and bit 30 clear gives `rst_req` high for the next cycle and leaves `first_rst_pend` unchanged.
- R8: With `addr_hi` = 0, `rdata` is 0 and a write has no effect on the word, on `first_rst_pend` or on `rst_req`.
- R9: `btn_por_evt` sets bit 28 and `btn_xir_evt` sets bit 27. An event wins over a write-1-to-clear of the same bit in the same cycle.
- R10: During a `sys_rst` cycle, bus writes and button events are ignored and `rst_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-up reset, active low, synchronous |
| sys_rst | input | 1 | System reset being applied, active high |
| btn_por_evt | input | 1 | Button power-on reset event |
| btn_xir_evt | input | 1 | Button externally-initiated reset event |
| wr_en | input | 1 | Bus write strobe |
| addr_hi | input | 1 | Address bit 2: 1 selects the register word |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data |
| rst_req | output | 1 | One-cycle system reset request |
| first_rst_pend | output | 1 | Next system reset is treated as power-on |

## Verification
The following are checked on every cycle by assertions:
- the first-reset load and the hold on later resets;
- the clear and set rules of each bit;
- the lower word reading zero;
- every `rst_req` pulse being traced to a qualifying write one cycle earlier.

Some behaviour shows up only in the bench's scenarios. One example is a whole sequence: a soft power-on write, followed by a reset that reloads bit 31 only, followed by a second reset that holds the word. Another is the exact values read back after mixed writes, button events and resets.

// File: rtl/rst_ctrl_stat.sv
module rst_ctrl_stat (
  input  logic        clk,
  input  logic        pwr_rst_n,
  input  logic        sys_rst,
  input  logic        btn_por_evt,
  input  logic        btn_xir_evt,
  input  logic        wr_en,
  input  logic        addr_hi,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rst_req,
  output logic        first_rst_pend
);
  localparam logic [31:0] LIVE_MASK = 32'hF800_0000;
  localparam logic [31:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [31:0] SET_MASK  = 32'h6000_0000;
  localparam logic [31:0] POR_ONLY  = 32'h8000_0000;
  localparam int          SOFT_POR  = 30;
  localparam int          SOFT_XIR  = 29;

  logic [31:0] stat;
  logic [31:0] wv;
  logic [31:0] evt;
  logic [31:0] nxt;

  assign wv  = (wr_en && addr_hi && !sys_rst) ? (wdata & LIVE_MASK) : 32'h0;
  assign evt = {3'b000, btn_por_evt, btn_xir_evt, 27'h0};
  assign nxt = (stat & ~(wv & W1C_MASK)) | (wv & SET_MASK) | evt;

  always_ff @(posedge clk) begin
    if (!pwr_rst_n) begin
      stat           <= 32'h0;
      first_rst_pend <= 1'b1;
      rst_req        <= 1'b0;
    end else if (sys_rst) begin
      if (first_rst_pend) begin
        stat           <= POR_ONLY;
        first_rst_pend <= 1'b0;
      end
      rst_req <= 1'b0;
    end else begin
      stat <= nxt;
      if (wv[SOFT_POR]) first_rst_pend <= 1'b1;
      rst_req <= wv[SOFT_POR] | wv[SOFT_XIR];
    end
  end

  assign rdata = addr_hi ? stat : 32'h0;
endmodule

module rst_ctrl_stat_chk (
  input logic        clk,
  input logic        pwr_rst_n,
  input logic        sys_rst,
  input logic        btn_por_evt,
  input logic        btn_xir_evt,
  input logic        wr_en,
  input logic        addr_hi,
  input logic [4:0]  wdata_hi,
  input logic [31:0] rdata,
  input logic        rst_req,
  input logic        first_rst_pend,
  input logic [31:0] stat
);
  logic wr_ok;
  assign wr_ok = wr_en && addr_hi && !sys_rst;

  p_first_load_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && first_rst_pend) |=> (stat == 32'h8000_0000 && !first_rst_pend));
  p_warm_hold_r2: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && !first_rst_pend) |=> $stable(stat));
  p_low_zero_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rdata[26:0] == 27'h0);
  p_w1c_por_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_ok && wdata_hi[4]) |=> !stat[31]);
  p_w1c_btn_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_ok && wdata_hi[1] && !btn_por_evt) |=> !stat[28]);
  p_set_xir_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_ok && wdata_hi[2]) |=> stat[29]);
  p_por_pend_r6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_ok && wdata_hi[3]) |=> (first_rst_pend && rst_req));
  p_req_src_r7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_req |-> $past(wr_ok && (wdata_hi[3] || wdata_hi[2])));
  p_lo_word_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !addr_hi |-> rdata == 32'h0);
  p_btn_xir_r9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (btn_xir_evt && !sys_rst) |=> stat[27]);
  p_no_req_in_rst_r10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    sys_rst |=> !rst_req);
endmodule

bind rst_ctrl_stat rst_ctrl_stat_chk u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst(sys_rst),
  .btn_por_evt(btn_por_evt), .btn_xir_evt(btn_xir_evt),
  .wr_en(wr_en), .addr_hi(addr_hi), .wdata_hi(wdata[31:27]),
  .rdata(rdata), .rst_req(rst_req), .first_rst_pend(first_rst_pend),
  .stat(stat)
);

// File: tb/tb_rst_ctrl_stat.sv
`timescale 1ns/1ps
module tb_rst_ctrl_stat;
  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0, sys_rst = 1'b0, btn_por_evt = 1'b0, btn_xir_evt = 1'b0;
  logic wr_en = 1'b0, addr_hi = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic rst_req, first_rst_pend;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_reg;
  logic m_pend, m_req;

  always #4 clk = ~clk;

  rst_ctrl_stat dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] next_reg(input logic [31:0] r, input logic [31:0] w,
                                           input logic bp, input logic bx);
    logic [31:0] m;
    m = w & 32'hF800_0000;
    return (r & ~(m & 32'h9800_0000)) | (m & 32'h6000_0000) | {3'b0, bp, bx, 27'h0};
  endfunction

  task automatic cyc(input string tag, input logic w, input logic hi, input logic [31:0] d,
                     input logic sr, input logic bp, input logic bx);
    wr_en = w; addr_hi = hi; wdata = d; sys_rst = sr; btn_por_evt = bp; btn_xir_evt = bx;
    if (sr) begin
      if (m_pend) begin m_reg = 32'h8000_0000; m_pend = 1'b0; end
      m_req = 1'b0;
    end else begin
      m_req = 1'b0;
      if (w && hi) begin
        m_reg = next_reg(m_reg, d, bp, bx);
        if (d[30]) m_pend = 1'b1;
        m_req = d[30] | d[29];
      end else begin
        m_reg = next_reg(m_reg, 32'h0, bp, bx);
      end
    end
    @(negedge clk);
    check({tag, " rdata"}, rdata, hi ? m_reg : 32'h0);
    check({tag, " pend"}, {31'h0, first_rst_pend}, {31'h0, m_pend});
    check({tag, " req"}, {31'h0, rst_req}, {31'h0, m_req});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_reg = 0; m_pend = 1; m_req = 0;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1;
    cyc("R1 after power-up", 0, 1, 0, 0, 0, 0);
    cyc("R2 first reset", 0, 1, 0, 1, 0, 0);
    cyc("R3 unused bits", 1, 1, 32'h07FF_FFFF, 0, 0, 0);
    cyc("R8 low word write", 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R8 readback", 0, 1, 0, 0, 0, 0);
    cyc("R4 write zero", 1, 1, 32'h0, 0, 0, 0);
    cyc("R4 clear bit31", 1, 1, 32'h8000_0000, 0, 0, 0);
    cyc("R9 button events", 0, 1, 0, 0, 1, 1);
    cyc("R9 event beats clear", 1, 1, 32'h1000_0000, 0, 1, 0);
    cyc("R4 clear bit27", 1, 1, 32'h0800_0000, 0, 0, 0);
    cyc("R7 soft xir", 1, 1, 32'h2000_0000, 0, 0, 0);
    cyc("R7 pulse ends", 0, 1, 0, 0, 0, 0);
    cyc("R5 write zero", 1, 1, 32'h0, 0, 0, 0);
    cyc("R10 write in reset", 1, 1, 32'h4000_0000, 1, 0, 1);
    cyc("R6 soft por", 1, 1, 32'h4000_0000, 0, 0, 0);
    cyc("R2 reload after soft por", 0, 1, 0, 1, 0, 0);
    cyc("R2 warm hold", 0, 1, 0, 1, 0, 0);
    begin
      int seed_dummy = $urandom(32'h5EED);
      if (seed_dummy < 0) $display("seeded");
    end
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & 32'hF800_0000;
      cyc("R2_R10 random", ($urandom_range(0, 2) != 0), ($urandom_range(0, 4) != 0), d,
          ($urandom_range(0, 19) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule